// File: doc/BRIEF.md
# Transmit-Only Display Identification Streamer

This block sends the contents of a 128-byte identification memory as a continuous serial stream on a shared open-drain data line. No bus master addresses it. A dedicated transmit clock paces the stream, one bit per rising edge. After reset the block waits through a synchronisation preamble of nine transmit-clock rises, with the line released. From then on it sends each byte most significant bit first. Each byte is followed by a ninth slot in which the line is released. The byte address advances after every frame and wraps from the last location back to location 0. The starting address after reset is defined as 0.

Both clock inputs are asynchronous to the system clock. Each one passes through a synchroniser and edge detector. The bidirectional-mode clock line is idle high. When a falling edge on it is confirmed, that is, when it is seen low on two consecutive samples after a high sample, the block gives up the data line for good. It clears its ownership flag, releases its drive, and then ignores the transmit clock. Only a reset brings it back into transmit-only operation.

The memory is read through a plain port: the block presents an address and takes the byte back combinationally. It captures the byte at the start of each frame.

Top module: `txs_stream_top`

## Requirements
- R1: While reset is asserted and right after it, `tx_owner_o` is 1, `sda_pull_o` is 0 (line released) and `rd_addr_o` is 0.
- R2: During the first nine transmit-clock rising edges after reset, `sda_pull_o` stays 0, whatever the memory holds.
- R3: On the tenth transmit-clock rise after reset, the block presents bit 7 of the byte at address 0. `sda_pull_o` = 1 means the line is pulled low (a 0 bit), and `sda_pull_o` = 0 means released (a 1 bit).
- R4: Each later rise presents the next bit of the current byte, from bit 7 down to bit 0, with one bit per rise.
- R5: The rise after bit 0 is the null slot, and `sda_pull_o` is 0 during it.
- R6: At the null slot `rd_addr_o` advances by one, and from 127 it wraps to 0. It changes at no other time.
- R7: While the block owns the line, `sda_pull_o` changes only in response to a transmit-clock rise.
- R8: A falling edge on `bd_clk_i` that is then sampled low twice in a row clears `tx_owner_o` and forces `sda_pull_o` to 0. A low lasting a single sample has no effect. Once cleared, `tx_owner_o` stays 0 whatever `bd_clk_i` does afterwards.
- R9: After ownership is given up, transmit-clock rises change neither `sda_pull_o` nor `rd_addr_o`.
- R10: Asserting reset again restores `tx_owner_o` = 1, address 0 and a fresh nine-rise preamble.
- R11: An output change caused by a transmit-clock rise appears on the second system-clock edge after the edge that first samples `tx_clk_i` high. A confirmed `bd_clk_i` fall takes effect on the third edge after the edge that first samples it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than either serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk_i | input | 1 | Transmit clock, asynchronous |
| bd_clk_i | input | 1 | Bidirectional-mode clock line, idle high, asynchronous |
| rd_addr_o | output | 7 | Memory read address |
| rd_data_i | input | 8 | Memory read data for `rd_addr_o` |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| tx_owner_o | output | 1 | 1 while this block owns the data-line drive |

## Verification
The bench targets the preamble boundary. A design that counts eight or ten rises would drive the first bit one rise too early or too late, and that shows against a memory whose byte 0 has bit 7 clear. It runs well past one full wrap of the 128 bytes. An off-by-one in the frame length, a driven null slot, or a missing wrap would make the stream drift from the expected bit. It sends a one-sample low glitch on the bidirectional clock, which a design without confirmation would mistake for a mode exit. It also checks that after a real exit, transmit-clock activity and a return of the clock line high leave the line released and the address frozen. It measures output latency against the synchroniser depth on the exact system-clock edge.

// File: rtl/txs_pkg.sv
package txs_pkg;

   // Which part of the stream the sequencer is in
   typedef enum logic [1:0] {
      PH_SYNC = 2'd0,
      PH_BITS = 2'd1,
      PH_NULL = 2'd2
   } txs_phase_e;

   // Slots appended after the data bits of every frame
   localparam int unsigned TXS_NULL_SLOTS = 1;

endpackage

// File: rtl/txs_edge_det.sv
module txs_edge_det #(
   parameter int unsigned SYNC    = 2,
   parameter int unsigned CONFIRM = 1,
   parameter bit          RISING  = 1'b1,
   parameter bit          RST_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic hit_o
);

   localparam int unsigned LEN = SYNC + CONFIRM;
   localparam bit          LVL = RISING;

   if (SYNC < 2) begin : g_bad_sync
      $error("txs_edge_det: SYNC must be at least 2");
   end
   if (CONFIRM < 1) begin : g_bad_conf
      $error("txs_edge_det: CONFIRM must be at least 1");
   end

   // q[0] is the newest sample; q[SYNC-1] is the first settled one
   logic [LEN-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {LEN{RST_LVL}};
      else        q <= {q[LEN-2:0], pin_i};
   end

   if (CONFIRM == 1) begin : g_single
      assign hit_o = (q[SYNC-1] == LVL) && (q[SYNC] != LVL);
   end else begin : g_multi
      logic held;
      always_comb begin
         held = 1'b1;
         for (int k = 0; k < int'(CONFIRM); k++) begin
            held = held & (q[SYNC-1+k] == LVL);
         end
      end
      assign hit_o = held && (q[LEN-1] != LVL);
   end

endmodule

// File: rtl/txs_mode_ctl.sv
module txs_mode_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic exit_i,
   output logic own_o
);

   // One-way flag: only reset sets it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      own_o <= 1'b1;
      else if (exit_i) own_o <= 1'b0;
   end

endmodule

// File: rtl/txs_frame_seq.sv
module txs_frame_seq
   import txs_pkg::*;
#(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned DW    = 8,
   parameter int unsigned PRE   = 9,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_i,
   input  logic          stop_i,
   input  logic [DW-1:0] rd_data_i,
   output logic [AW-1:0] rd_addr_o,
   output logic          pull_o,
   output logic          in_sync_o
);

   localparam int unsigned PW    = $clog2(PRE + 1);
   localparam int unsigned SLOTS = DW + TXS_NULL_SLOTS;
   localparam int unsigned BW    = $clog2(SLOTS + 1);
   localparam logic [PW-1:0] PRE_END  = PW'(PRE);
   localparam logic [BW-1:0] NULL_IDX = BW'(DW);
   localparam logic [AW-1:0] LAST_A   = AW'(DEPTH - 1);

   logic [PW-1:0] pre_q;
   logic [BW-1:0] slot_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] addr_nxt;
   logic [DW-1:0] shf_q;
   logic          pull_q;
   txs_phase_e    phase;

   // Address successor: free wrap for powers of two, compare otherwise
   if (DEPTH == (1 << AW)) begin : g_pow2
      assign addr_nxt = addr_q + AW'(1);
   end else begin : g_cmp
      assign addr_nxt = (addr_q == LAST_A) ? '0 : addr_q + AW'(1);
   end

   always_comb begin
      if (pre_q != PRE_END)      phase = PH_SYNC;
      else if (slot_q == NULL_IDX) phase = PH_NULL;
      else                       phase = PH_BITS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         slot_q <= '0;
         addr_q <= '0;
         shf_q  <= '0;
         pull_q <= 1'b0;
      end else if (stop_i) begin
         pull_q <= 1'b0;
      end else if (step_i) begin
         case (phase)
            PH_SYNC: begin
               pre_q  <= pre_q + PW'(1);
               pull_q <= 1'b0;
            end
            PH_NULL: begin
               slot_q <= '0;
               addr_q <= addr_nxt;
               pull_q <= 1'b0;
            end
            default: begin
               slot_q <= slot_q + BW'(1);
               if (slot_q == '0) begin
                  pull_q <= ~rd_data_i[DW-1];
                  shf_q  <= rd_data_i << 1;
               end else begin
                  pull_q <= ~shf_q[DW-1];
                  shf_q  <= shf_q << 1;
               end
            end
         endcase
      end
   end

   assign rd_addr_o = addr_q;
   assign pull_o    = pull_q;
   assign in_sync_o = (phase == PH_SYNC);

endmodule

// File: rtl/txs_stream_top.sv
module txs_stream_top #(
   parameter int unsigned DEPTH   = 128,
   parameter int unsigned DW      = 8,
   parameter int unsigned PRE     = 9,
   parameter int unsigned SYNC    = 2,
   parameter int unsigned CONFIRM = 2,
   parameter int unsigned AW      = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_clk_i,
   input  logic          bd_clk_i,
   output logic [AW-1:0] rd_addr_o,
   input  logic [DW-1:0] rd_data_i,
   output logic          sda_pull_o,
   output logic          tx_owner_o
);

   if (DEPTH < 2)  begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (DW < 2)     begin : g_bad_dw    $error("DW must be at least 2"); end
   if (PRE < 1)    begin : g_bad_pre   $error("PRE must be at least 1"); end
   if (AW != $clog2(DEPTH)) begin : g_bad_aw $error("AW must match DEPTH"); end

   logic tx_rise;
   logic bd_fall;
   logic tx_step;
   logic in_sync;

   txs_edge_det #(
      .SYNC(SYNC), .CONFIRM(1), .RISING(1'b1), .RST_LVL(1'b0)
   ) u_tx_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(tx_clk_i), .hit_o(tx_rise)
   );

   txs_edge_det #(
      .SYNC(SYNC), .CONFIRM(CONFIRM), .RISING(1'b0), .RST_LVL(1'b1)
   ) u_bd_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(bd_clk_i), .hit_o(bd_fall)
   );

   txs_mode_ctl u_mode (
      .clk(clk), .rst_n(rst_n), .exit_i(bd_fall), .own_o(tx_owner_o)
   );

   assign tx_step = tx_rise & tx_owner_o;

   txs_frame_seq #(
      .DEPTH(DEPTH), .DW(DW), .PRE(PRE), .AW(AW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .step_i(tx_step), .stop_i(bd_fall),
      .rd_data_i(rd_data_i), .rd_addr_o(rd_addr_o),
      .pull_o(sda_pull_o), .in_sync_o(in_sync)
   );

endmodule

// File: rtl/txs_stream_chk.sv
module txs_stream_chk #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode,
   input logic          drive,
   input logic [AW-1:0] addr,
   input logic          step,
   input logic          in_sync
);

   // R2
   sync_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_sync |-> !drive);

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != $past(addr)) |-> (int'(addr) == (int'($past(addr)) + 1) % int'(DEPTH)));

   // R7
   drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && $past(mode) && !$past(step)) |-> $stable(drive));

   // R8
   mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |=> !mode);

   // R8
   exit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |-> !drive);

   // R9
   frozen_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode) |-> $stable(addr));

endmodule

bind txs_stream_top txs_stream_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(tx_owner_o), .drive(sda_pull_o),
   .addr(rd_addr_o), .step(tx_step), .in_sync(in_sync)
);

// File: tb/tb_txs_stream_top.sv
module tb_txs_stream_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_clk = 1'b0;
   logic       bd_clk = 1'b1;
   logic [6:0] rd_addr;
   logic [7:0] rd_data;
   logic       sda_pull;
   logic       tx_owner;

   logic [7:0] mem [128];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   txs_stream_top dut (
      .clk(clk), .rst_n(rst_n), .tx_clk_i(tx_clk), .bd_clk_i(bd_clk),
      .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .sda_pull_o(sda_pull), .tx_owner_o(tx_owner)
   );

   assign rd_data = mem[rd_addr];

   initial begin
      for (int a = 0; a < 128; a++) mem[a] = 8'((a * 53 + 17) ^ (a >> 2));
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: sample histories, preamble count, bit queue
   int th[$];
   int bh[$];
   int m_pre, m_addr, m_own, m_pull;
   int m_bits[$];

   task automatic model_reset();
      th = '{0, 0, 0, 0};
      bh = '{1, 1, 1, 1, 1};
      m_pre = 0; m_addr = 0; m_own = 1; m_pull = 0;
      m_bits.delete();
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         th.push_front(int'(tx_clk)); void'(th.pop_back());
         bh.push_front(int'(bd_clk)); void'(bh.pop_back());
         if (bh[2] == 0 && bh[3] == 0 && bh[4] == 1) begin
            m_own = 0; m_pull = 0;
         end else if (m_own == 1 && th[2] == 1 && th[3] == 0) begin
            if (m_pre < 9) begin
               m_pre++; m_pull = 0;
            end else begin
               if (m_bits.size() == 0) begin
                  for (int b = 7; b >= 0; b--) m_bits.push_back(int'(mem[m_addr][b]));
                  m_bits.push_back(-1);
               end
               if (m_bits[0] < 0) begin
                  m_pull = 0; m_addr = (m_addr + 1) % 128;
               end else begin
                  m_pull = 1 - m_bits[0];
               end
               void'(m_bits.pop_front());
            end
         end
      end
   end

   // Every-clock comparison against the reference (R4 R5 R6 R8 R11)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(int'(sda_pull) == m_pull, "R4/R11 line", int'(sda_pull), m_pull);
         check(int'(tx_owner) == m_own, "R8 owner", int'(tx_owner), m_own);
         check(int'(rd_addr) == m_addr, "R6 addr", int'(rd_addr), m_addr);
      end
   end

   task automatic do_reset();
      @(negedge clk); #1 rst_n = 1'b0;
      tx_clk = 1'b0; bd_clk = 1'b1;
      repeat (3) @(negedge clk);
      check(tx_owner == 1'b1, "R1 owner", int'(tx_owner), 1);
      check(sda_pull == 1'b0, "R1 line", int'(sda_pull), 0);
      check(rd_addr == 7'd0, "R1 addr", int'(rd_addr), 0);
      #1 rst_n = 1'b1;
   endtask

   task automatic rise_half();
      @(negedge clk); tx_clk = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic fall_half();
      tx_clk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic int exp_pull(input int r);
      int s;
      if (r <= 9) return 0;
      s = (r - 10) % 9;
      if (s == 8) return 0;
      return 1 - int'(mem[((r - 10) / 9) % 128][7 - s]);
   endfunction

   function automatic int exp_addr(input int r);
      if (r < 9) return 0;
      return ((r - 9) / 9) % 128;
   endfunction

   initial begin
      int hold_addr;
      do_reset();
      repeat (3) @(negedge clk);
      check(sda_pull == 1'b0, "R1 line idle", int'(sda_pull), 0);

      // Main stream, past one full wrap
      for (int r = 1; r <= 1175; r++) begin
         rise_half();
         if (r <= 9)
            check(int'(sda_pull) == 0, "R2 preamble", int'(sda_pull), 0);
         else if (r == 10)
            check(int'(sda_pull) == exp_pull(r), "R3 first bit", int'(sda_pull), exp_pull(r));
         else if ((r - 10) % 9 == 8)
            check(int'(sda_pull) == 0, "R5 null slot", int'(sda_pull), 0);
         else
            check(int'(sda_pull) == exp_pull(r), "R4 bit", int'(sda_pull), exp_pull(r));
         check(int'(rd_addr) == exp_addr(r), "R6 address", int'(rd_addr), exp_addr(r));
         fall_half();
         // R7: held between rises
         check(int'(sda_pull) == exp_pull(r), "R7 hold", int'(sda_pull), exp_pull(r));
      end

      // One-sample glitch on the bidirectional clock
      @(negedge clk); bd_clk = 1'b0;
      @(negedge clk); bd_clk = 1'b1;
      repeat (6) @(negedge clk);
      check(tx_owner == 1'b1, "R8 glitch ignored", int'(tx_owner), 1);

      // Real exit
      @(negedge clk); bd_clk = 1'b0;
      repeat (6) @(negedge clk);
      check(tx_owner == 1'b0, "R8 exit", int'(tx_owner), 0);
      check(sda_pull == 1'b0, "R8 released", int'(sda_pull), 0);
      hold_addr = int'(rd_addr);
      bd_clk = 1'b1;
      for (int r = 0; r < 20; r++) begin
         rise_half();
         check(sda_pull == 1'b0, "R9 line", int'(sda_pull), 0);
         fall_half();
      end
      check(int'(rd_addr) == hold_addr, "R9 addr", int'(rd_addr), hold_addr);
      @(negedge clk); bd_clk = 1'b0;
      repeat (4) @(negedge clk); bd_clk = 1'b1;
      repeat (6) @(negedge clk);
      check(tx_owner == 1'b0, "R8 sticky", int'(tx_owner), 0);

      // Re-entry through reset only
      do_reset();
      repeat (3) @(negedge clk);
      check(tx_owner == 1'b1, "R10 owner", int'(tx_owner), 1);
      for (int r = 1; r <= 9; r++) begin
         rise_half();
         check(sda_pull == 1'b0, "R10 preamble", int'(sda_pull), 0);
         fall_half();
      end
      // Tenth rise, edge-exact latency; byte 0 bit 7 is 0 so the line pulls
      @(negedge clk); tx_clk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(sda_pull == 1'b0, "R11 not yet", int'(sda_pull), 0);
      @(negedge clk);
      check(sda_pull == 1'b1, "R11 updated", int'(sda_pull), 1);
      repeat (3) @(negedge clk);
      // Exit while pulling low, edge-exact latency
      bd_clk = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check(sda_pull == 1'b1, "R11 exit not yet", int'(sda_pull), 1);
      @(negedge clk);
      check(sda_pull == 1'b0, "R8 exit releases", int'(sda_pull), 0);
      check(tx_owner == 1'b0, "R11 exit owner", int'(tx_owner), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule